// File: doc/BRIEF.md
# Synchronous Serial Shift Interface

This block moves 8-bit or 16-bit words over a serial data-out line and a serial data-in line, least significant bit first, paced by a serial clock. The clock is either made on chip by a power-of-two prescaler of the system clock, or taken from an external source. The clock pin is modelled as an input, an output and an output enable. Software sets the mode, clock source and divider in a control register and loads the outgoing bytes. It then raises a start flag and polls a status register until the transfer has finished, and reads the received bytes back from the same data registers.

A free-running clock mode drives the divided clock on the pin without a break, whether or not a transfer is running. When the clock comes from outside, the block watches for clock activity that arrives after a word has finished but before software has collected it, and raises an overrun flag.

The register bus is synchronous. A write takes effect at the clock edge where `bus_wr` is high. A read returns its data on `bus_rdata` one cycle after `bus_rd`. The register addresses are 0 control, 1 status, 2 lower data byte and 3 upper data byte.

Top module: `sync_serial_if`

## Requirements
- R1: Control bits [1:0] set the transfer kind: 00 shifts 8 bits using only the lower data byte (address 2), and leaves the upper byte (address 3) untouched. 01 shifts 16 bits, with the lower byte holding bits 7..0 and the upper byte holding bits 15..8. 10 turns on the free-running clock and shifts 8 bits.
- R2: The transmitted word leaves on `sdo` least significant bit first.
- R3: Each `sdo` bit changes only where the serial clock falls and holds until the next falling edge.
- R4: `sdi` is captured where the serial clock rises, and the received word replaces the data register contents at completion.
- R5: With the internal clock, control bits [4:2] = 0..7 give a serial clock period of 2, 4, 8, 16, 32, 64, 256 and 1024 system clocks.
- R6: Control bit 5 = 0 selects the internal clock and drives the pin (`sck_oe` = 1). Bit 5 = 1 selects the external clock on `sck_in` and releases the pin (`sck_oe` = 0).
- R7: In free-running mode with the internal clock, `sck_out` toggles continuously with no start flag set. Otherwise the internal clock idles high between transfers.
- R8: Any write to the control register abandons a transfer in progress, clears busy, done and overrun, and returns the internal clock to high.
- R9: Writing status bit 0 = 1 while idle starts a transfer. Status bit 0 reads 1 while busy. At the last bit it returns to 0 and status bit 1 (done) is set.
- R10: Status bit 2 (overrun) is set only with the external clock, by a falling edge of `sck_in` that arrives after completion and before the lower data byte has been read. A new start or a control write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| sck_in | input | 1 | Serial clock from the pin (external source) |
| sck_out | output | 1 | Serial clock driven to the pin |
| sck_oe | output | 1 | Serial clock pin output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The bench runs loopback transfers in both word lengths, at several dividers, and in free-running mode. A design that shifted the wrong width or lost the upper byte returns a corrupted word. With a slow external clock it checks every bit on `sdo` against the LSB-first order. It also confirms that each bit holds through the high phase, so a design that changed data on the rising edge or sampled on the falling edge is exposed. It measures the clock half period for the shortest, a middle and the longest divider, where an off-by-one prescaler shows up at once. It drives stray external edges before and after the data read, and with the internal clock selected, to catch an overrun flag that fires in the wrong case or never fires. It also aborts a slow transfer with a control write, to catch leftover busy or clock state.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int MAX_HALF = 512;
  localparam int CNT_W    = $clog2(MAX_HALF);

  typedef enum logic [1:0] {
    MODE_B8   = 2'b00,
    MODE_B16  = 2'b01,
    MODE_FREE = 2'b10,
    MODE_RSVD = 2'b11
  } xfer_mode_e;

  typedef struct packed {
    logic       ext_clk;
    logic [2:0] div_sel;
    xfer_mode_e mode;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DLO  = 2'd2;
  localparam logic [1:0] ADDR_DHI  = 2'd3;

  // system clocks per half period of the serial clock
  function automatic int unsigned half_period(input logic [2:0] sel);
    case (sel)
      3'd6:    half_period = 128;
      3'd7:    half_period = 512;
      default: half_period = 1 << sel;
    endcase
  endfunction
endpackage

// File: rtl/ssi_clkgen.sv
module ssi_clkgen
  import ssi_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       sck,
  output logic       fall_now,
  output logic       rise_now
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] half_m1;
  logic          wrap;

  assign half_m1  = CW'(half_period(sel) - 1);
  assign wrap     = run && !clear && (cnt == half_m1);
  assign fall_now = wrap && sck;
  assign rise_now = wrap && !sck;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (wrap) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ssi_edge_sync.sv
module ssi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall_ev,
  output logic rise_ev
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain   <= '1;
      prev    <= 1'b1;
      fall_ev <= 1'b0;
      rise_ev <= 1'b0;
    end else begin
      chain   <= {chain[STAGES-2:0], pin};
      prev    <= chain[STAGES-1];
      fall_ev <= prev && !chain[STAGES-1];
      rise_ev <= !prev && chain[STAGES-1];
    end
  end
endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          start,
  input  logic          len16,
  input  logic          fall_ev,
  input  logic          rise_ev,
  input  logic          sdi,
  input  logic [2*BW-1:0] tx_word,
  output logic          busy,
  output logic          sdo,
  output logic          rx_valid,
  output logic [2*BW-1:0] rx_word
);
  localparam int WW = 2 * BW;
  localparam int IW = $clog2(WW);

  logic [WW-1:0] sh;
  logic [IW-1:0] bit_idx;
  logic [IW-1:0] last_idx;
  logic          len_q;
  logic          armed;
  logic [WW-1:0] sh_next;

  assign last_idx = len_q ? IW'(WW - 1) : IW'(BW - 1);
  assign sh_next  = len_q ? {sdi, sh[WW-1:1]} : {sh[WW-1:BW], sdi, sh[BW-1:1]};
  assign rx_word  = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      armed    <= 1'b0;
      bit_idx  <= '0;
      sh       <= '0;
      sdo      <= 1'b1;
      len_q    <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (abort) begin
        busy    <= 1'b0;
        armed   <= 1'b0;
        bit_idx <= '0;
      end else if (start && !busy) begin
        busy    <= 1'b1;
        armed   <= 1'b0;
        bit_idx <= '0;
        sh      <= tx_word;
        len_q   <= len16;
      end else if (busy) begin
        if (fall_ev) begin
          sdo   <= sh[0];
          armed <= 1'b1;
        end
        if (rise_ev && armed) begin
          sh <= sh_next;
          if (bit_idx == last_idx) begin
            busy     <= 1'b0;
            armed    <= 1'b0;
            rx_valid <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sync_serial_if.sv
module sync_serial_if
  import ssi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       sdi,
  output logic       sdo
);
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] dlo_q, dhi_q;
  logic              done_q, ovr_q, unread_q;
  logic              busy, rx_valid;
  logic [WORD_W-1:0] rx_word;
  logic              wr_ctrl, start_req, rd_dlo;
  logic              ext, free_run, gen_run;
  logic              i_fall, i_rise, x_fall, x_rise;
  logic              fall_ev, rise_ev;

  assign ext       = ctrl_q.ext_clk;
  assign free_run  = (ctrl_q.mode == MODE_FREE) && !ext;
  assign gen_run   = free_run || (busy && !ext);
  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
  assign start_req = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[0] && !busy;
  assign rd_dlo    = bus_rd && (bus_addr == ADDR_DLO);
  assign fall_ev   = ext ? x_fall : i_fall;
  assign rise_ev   = ext ? x_rise : i_rise;
  assign sck_oe    = !ext;

  ssi_clkgen u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .clear    (wr_ctrl),
    .run      (gen_run),
    .sel      (ctrl_q.div_sel),
    .sck      (sck_out),
    .fall_now (i_fall),
    .rise_now (i_rise)
  );

  ssi_edge_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin     (sck_in),
    .fall_ev (x_fall),
    .rise_ev (x_rise)
  );

  ssi_shifter #(.BW(BYTE_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .abort    (wr_ctrl),
    .start    (start_req),
    .len16    (ctrl_q.mode == MODE_B16),
    .fall_ev  (fall_ev),
    .rise_ev  (rise_ev),
    .sdi      (sdi),
    .tx_word  ({dhi_q, dlo_q}),
    .busy     (busy),
    .sdo      (sdo),
    .rx_valid (rx_valid),
    .rx_word  (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      dlo_q    <= '0;
      dhi_q    <= '0;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
      unread_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= ctrl_t'(bus_wdata[5:0]);
      end
      if (bus_wr && bus_addr == ADDR_DLO) dlo_q <= bus_wdata;
      if (bus_wr && bus_addr == ADDR_DHI) dhi_q <= bus_wdata;
      if (rx_valid) begin
        dlo_q <= rx_word[BYTE_W-1:0];
        if (ctrl_q.mode == MODE_B16) dhi_q <= rx_word[WORD_W-1:BYTE_W];
      end

      if (wr_ctrl || start_req) done_q <= 1'b0;
      else if (rx_valid)        done_q <= 1'b1;

      if (wr_ctrl || start_req) unread_q <= 1'b0;
      else if (rx_valid)        unread_q <= 1'b1;
      else if (rd_dlo)          unread_q <= 1'b0;

      if (wr_ctrl || start_req)                     ovr_q <= 1'b0;
      else if (ext && !busy && unread_q && x_fall)  ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_CTRL: bus_rdata <= {2'b00, ctrl_q};
        ADDR_STAT: bus_rdata <= {5'b0, ovr_q, done_q, busy};
        ADDR_DLO:  bus_rdata <= dlo_q;
        default:   bus_rdata <= dhi_q;
      endcase
    end
  end
endmodule

// File: rtl/ssi_checker.sv
module ssi_checker (
  input logic       clk,
  input logic       rst,
  input logic       sck_out,
  input logic       sck_oe,
  input logic       sdo,
  input logic       busy,
  input logic       done,
  input logic       ovr,
  input logic       ext,
  input logic [1:0] mode,
  input logic [2:0] sel,
  input logic       ctrl_wr
);
  logic free_fast;
  assign free_fast = (mode == 2'b10) && !ext && (sel == 3'd0);

  AST_SDO_HELD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sck_oe && $past(sck_oe) && $rose(sck_out)) |-> $stable(sdo)); // R3

  AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9

  AST_NO_OVERRUN_INTERNAL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !ext && !$past(ext)) |-> !$rose(ovr)); // R10

  AST_OVERRUN_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(ovr)) |-> !busy); // R10

  AST_FREE_CLOCK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(free_fast) && !$past(ctrl_wr)) |-> (sck_out != $past(sck_out))); // R7
endmodule

bind sync_serial_if ssi_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .sck_out (sck_out),
  .sck_oe  (sck_oe),
  .sdo     (sdo),
  .busy    (busy),
  .done    (done_q),
  .ovr     (ovr_q),
  .ext     (ctrl_q.ext_clk),
  .mode    (ctrl_q.mode),
  .sel     (ctrl_q.div_sel),
  .ctrl_wr (wr_ctrl)
);

// File: tb/tb_sync_serial_if.sv
module tb_sync_serial_if;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       sck_in = 1'b1;
  logic       sck_out, sck_oe, sdo, sdi;
  logic       loop_en = 1'b1;
  logic       sdi_drv = 1'b0;
  int         n_chk = 0;
  int         n_err = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;
  assign sdi = loop_en ? sdo : sdi_drv;

  sync_serial_if dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo)
  );

  // {mode[1:0], sel[2:0], pad[2:0], word[15:0]}
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {2'b00, 3'd0, 3'd0, 16'h3CA5},
    {2'b01, 3'd0, 3'd0, 16'h1234},
    {2'b01, 3'd1, 3'd0, 16'h8001},
    {2'b00, 3'd2, 3'd0, 16'h77FF},
    {2'b10, 3'd0, 3'd0, 16'hC35A},
    {2'b01, 3'd3, 3'd0, 16'hFFFE}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_done(output logic [7:0] st);
    st = 8'h01;
    for (int k = 0; k < 5000; k++) begin
      rd(2'd1, st);
      if (!st[0]) break;
    end
  endtask

  task automatic measure_half(output int h);
    logic p;
    h = 0;
    @(negedge clk); p = sck_out;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (sck_out != p) break;
    end
    p = sck_out;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      h++;
      if (sck_out != p) break;
    end
  endtask

  function automatic int exp_half(input int sel);
    int per;
    per = (sel == 6) ? 256 : (sel == 7) ? 1024 : (2 << sel);
    return per / 2;
  endfunction

  task automatic ext_xfer(input logic [7:0] tx, input logic [7:0] rxp);
    wr(2'd0, 8'h20);
    wr(2'd2, tx);
    wr(2'd1, 8'h01);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sck_in = 1'b0; sdi_drv = rxp[i];
      repeat (6) @(negedge clk);
      chk("R2 bit after falling edge", int'(sdo), int'(tx[i]));
      sck_in = 1'b1;
      repeat (6) @(negedge clk);
      chk("R3 bit held through high phase", int'(sdo), int'(tx[i]));
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_ext();
    @(negedge clk); sck_in = 1'b0;
    repeat (6) @(negedge clk); sck_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, lo, hi;
    int h;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(2'd1, st);
    chk("R9 status after reset", int'(st), 0);
    chk("R6 pin driven after reset", int'(sck_oe), 1);
    chk("R7 clock idle high after reset", int'(sck_out), 1);

    // loopback vectors
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  m;
      logic [2:0]  s;
      logic [15:0] w;
      m = VEC[v][23:22]; s = VEC[v][21:19]; w = VEC[v][15:0];
      loop_en = 1'b1;
      wr(2'd0, {2'b00, 1'b0, s, m});
      wr(2'd2, w[7:0]);
      wr(2'd3, w[15:8]);
      wr(2'd1, 8'h01);
      rd(2'd1, st);
      chk("R9 busy after start", int'(st[0]), 1);
      wait_done(st);
      chk("R9 done and idle", int'(st[2:0]), 3'b010);
      rd(2'd2, lo);
      rd(2'd3, hi);
      chk("R1 R4 lower byte loopback", int'(lo), int'(w[7:0]));
      chk("R1 upper byte", int'(hi), int'(w[15:8]));
      if (m != 2'b10) begin
        repeat (3) @(negedge clk);
        chk("R7 internal clock idles high", int'(sck_out), 1);
      end
    end

    // 8-bit transfer with external data into the lower byte; upper untouched
    loop_en = 1'b0;
    wr(2'd3, 8'h5E);
    ext_xfer(8'hB4, 8'h69);
    rd(2'd1, st);
    chk("R9 external transfer done", int'(st[2:0]), 3'b010);
    chk("R6 pin released with external clock", int'(sck_oe), 0);

    // overrun: edge after completion, before read
    pulse_ext();
    rd(2'd1, st);
    chk("R10 overrun set by late edge", int'(st[2]), 1);
    rd(2'd2, lo);
    chk("R4 received byte external clock", int'(lo), 8'h69);
    rd(2'd3, hi);
    chk("R1 upper byte untouched in 8-bit mode", int'(hi), 8'h5E);

    // no overrun when data already read
    ext_xfer(8'h0F, 8'hA3);
    rd(2'd2, lo);
    chk("R4 second external byte", int'(lo), 8'hA3);
    pulse_ext();
    rd(2'd1, st);
    chk("R10 no overrun after data read", int'(st[2]), 0);

    // internal clock: external edges ignored
    loop_en = 1'b1;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h81);
    wr(2'd1, 8'h01);
    wait_done(st);
    pulse_ext();
    rd(2'd1, st);
    chk("R10 no overrun with internal clock", int'(st[2:0]), 3'b010);

    // free-running clock periods
    for (int s = 0; s < 8; s++) begin
      if (s == 0 || s == 2 || s == 5 || s == 7) begin
        wr(2'd0, {2'b00, 1'b0, 3'(s), 2'b10});
        measure_half(h);
        chk("R5 R7 half period of free clock", h, exp_half(s));
      end
    end
    rd(2'd1, st);
    chk("R7 free clock with no transfer", int'(st[0]), 0);

    // abort by control write
    wr(2'd0, {2'b00, 1'b0, 3'd7, 2'b01});
    wr(2'd1, 8'h01);
    repeat (700) @(negedge clk);
    rd(2'd1, st);
    chk("R9 busy during slow transfer", int'(st[0]), 1);
    chk("R8 clock low mid transfer", int'(sck_out), 0);
    wr(2'd0, {2'b00, 1'b0, 3'd7, 2'b01});
    rd(2'd1, st);
    chk("R8 control write aborts", int'(st[2:0]), 0);
    chk("R8 clock back high", int'(sck_out), 1);
    wr(2'd0, 8'h20);
    chk("R6 external select releases pin", int'(sck_oe), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule